// File: doc/BRIEF.md
# Low-Power Packet Disposition Filter

This block sits beside the receive path of a switch port and decides what happens to each transaction-layer packet while the port is in the D3hot power state. For every packet it is given the packet's kind, the side it arrived on, and whether the bridge itself is the target. From these it returns one disposition code: the packet is accepted, it is rejected as an unsupported request, it is flagged as an unexpected completion, or it is handled normally (routed as in D0). The code appears one cycle after the packet strobe, together with an output valid.

The block also gates the port's error events. Each error source carries a tag that says whether a received packet caused the event. In D3hot, an event caused by a received packet is still reported. An event with any other cause is dropped. Outside D3hot, every event passes. The gated strobes are registered, so they have the same one-cycle latency as the disposition.

Packet parsing, completion generation and message formation belong to the neighbouring logic. This block produces only the decision and the gated strobes.

Top module: `lp_tlp_filter`

## Requirements
- R1: `disp_valid_o` is high in the cycle after a cycle with `pkt_valid_i` high, and low in the cycle after a cycle with `pkt_valid_i` low.
- R2: When `d3hot_i` is low, every packet gets disposition NORMAL (code 0), whatever its kind, side or target.
- R3: In D3hot, a type 0 configuration packet (kind 0) arriving on the primary side (`pkt_side_i`=0) gets ACCEPT (code 1).
- R4: In D3hot, a message (kind 3) arriving on the primary side with `pkt_to_self_i` high gets ACCEPT (code 1).
- R5: In D3hot, any other request on the primary side gets UNSUP_REQ (code 2). This covers kind 1 (other configuration), kind 2 (memory/IO), a message not aimed at the bridge, and reserved kinds 5 to 7.
- R6: In D3hot, every non-completion packet arriving on the secondary side (`pkt_side_i`=1) gets UNSUP_REQ (code 2), including type 0 configuration and messages aimed at the bridge.
- R7: In D3hot, a completion (kind 4) with `pkt_to_self_i` high gets UNEXP_CPL (code 3), on either side.
- R8: A completion with `pkt_to_self_i` low gets NORMAL (code 0) on either side and in either power state.
- R9: In D3hot, an error event whose `err_from_pkt_i` bit is high raises the matching `err_report_o` bit in the next cycle.
- R10: In D3hot, an error event whose `err_from_pkt_i` bit is low leaves its `err_report_o` bit low in the next cycle.
- R11: When `d3hot_i` is low, each `err_valid_i` bit appears on `err_report_o` in the next cycle, regardless of its tag.
- R12: While `rst_ni` is low, `disp_valid_o`, `disp_code_o` and `err_report_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pkt_valid_i | input | 1 | Packet descriptor strobe |
| pkt_kind_i | input | 3 | Kind: 0 cfg type 0, 1 other cfg, 2 mem/IO, 3 message, 4 completion, 5-7 reserved |
| pkt_side_i | input | 1 | Arrival side: 0 primary, 1 secondary |
| pkt_to_self_i | input | 1 | Packet is aimed at the bridge itself |
| d3hot_i | input | 1 | Port is in D3hot |
| err_valid_i | input | N_ERR (4) | Error event strobes, one per source |
| err_from_pkt_i | input | N_ERR (4) | Per-source tag: event caused by a received packet |
| disp_valid_o | output | 1 | Disposition valid, one cycle after the strobe |
| disp_code_o | output | 2 | 0 NORMAL, 1 ACCEPT, 2 UNSUP_REQ, 3 UNEXP_CPL |
| err_report_o | output | N_ERR (4) | Gated error report strobes |

## Verification
Two functions can act in the same cycle: the classification of a packet and the gating of error events. Both read the same `d3hot_i` sample. The bench sets a packet strobe, a mix of packet-caused and other error events, and a change of `d3hot_i` all in one cycle. It then checks the disposition code and every `err_report_o` bit together, one cycle later. If either path uses a stale or mismatched power-state sample, the check shows it: a D3hot-only code appears with unfiltered errors, or the reverse.

// File: rtl/lp_tlp_filter_pkg.sv
package lp_tlp_filter_pkg;

  typedef enum logic [2:0] {
    KIND_CFG0   = 3'd0,
    KIND_CFGX   = 3'd1,
    KIND_MEMIO  = 3'd2,
    KIND_MSG    = 3'd3,
    KIND_CPL    = 3'd4
  } pkt_kind_e;

  typedef enum logic [1:0] {
    DISP_NORMAL = 2'd0,
    DISP_ACCEPT = 2'd1,
    DISP_UR     = 2'd2,
    DISP_UC     = 2'd3
  } disp_e;

  typedef struct packed {
    logic [2:0] kind;
    logic       side;
    logic       to_self;
  } pkt_desc_t;

endpackage

// File: rtl/lp_tlp_classifier.sv
module lp_tlp_classifier
  import lp_tlp_filter_pkg::*;
(
  input  pkt_desc_t desc_i,
  input  logic      d3hot_i,
  output disp_e     disp_o
);

  logic is_cpl;
  logic is_cfg0;
  logic is_msg;
  logic from_sec;

  assign is_cpl   = (desc_i.kind == KIND_CPL);
  assign is_cfg0  = (desc_i.kind == KIND_CFG0);
  assign is_msg   = (desc_i.kind == KIND_MSG);
  assign from_sec = desc_i.side;

  always_comb begin
    disp_o = DISP_NORMAL;
    if (d3hot_i) begin
      if (is_cpl) begin
        // pass-through completions keep routing as in D0
        disp_o = desc_i.to_self ? DISP_UC : DISP_NORMAL;
      end else if (from_sec) begin
        disp_o = DISP_UR;
      end else if (is_cfg0 || (is_msg && desc_i.to_self)) begin
        disp_o = DISP_ACCEPT;
      end else begin
        disp_o = DISP_UR;
      end
    end
  end

endmodule

// File: rtl/lp_err_gate.sv
module lp_err_gate #(
  parameter int unsigned N_ERR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d3hot_i,
  input  logic [N_ERR-1:0] err_valid_i,
  input  logic [N_ERR-1:0] err_from_pkt_i,
  output logic [N_ERR-1:0] err_report_o
);

  for (genvar g = 0; g < N_ERR; g++) begin : g_src
    logic pass;
    assign pass = err_valid_i[g] & (~d3hot_i | err_from_pkt_i[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_report_o[g] <= 1'b0;
      else         err_report_o[g] <= pass;
    end
  end

endmodule

// File: rtl/lp_disp_stage.sv
module lp_disp_stage
  import lp_tlp_filter_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  disp_e disp_i,
  output logic  valid_o,
  output disp_e disp_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      disp_o  <= DISP_NORMAL;
    end else begin
      valid_o <= valid_i;
      disp_o  <= valid_i ? disp_i : DISP_NORMAL;
    end
  end

endmodule

// File: rtl/lp_tlp_filter.sv
module lp_tlp_filter
  import lp_tlp_filter_pkg::*;
#(
  parameter int unsigned N_ERR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_valid_i,
  input  logic [2:0]       pkt_kind_i,
  input  logic             pkt_side_i,
  input  logic             pkt_to_self_i,
  input  logic             d3hot_i,
  input  logic [N_ERR-1:0] err_valid_i,
  input  logic [N_ERR-1:0] err_from_pkt_i,
  output logic             disp_valid_o,
  output logic [1:0]       disp_code_o,
  output logic [N_ERR-1:0] err_report_o
);

  pkt_desc_t desc;
  disp_e     disp_comb;
  disp_e     disp_q;

  assign desc.kind    = pkt_kind_i;
  assign desc.side    = pkt_side_i;
  assign desc.to_self = pkt_to_self_i;

  lp_tlp_classifier u_cls (
    .desc_i  (desc),
    .d3hot_i (d3hot_i),
    .disp_o  (disp_comb)
  );

  lp_disp_stage u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (pkt_valid_i),
    .disp_i  (disp_comb),
    .valid_o (disp_valid_o),
    .disp_o  (disp_q)
  );

  assign disp_code_o = disp_q;

  lp_err_gate #(.N_ERR(N_ERR)) u_err (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .d3hot_i        (d3hot_i),
    .err_valid_i    (err_valid_i),
    .err_from_pkt_i (err_from_pkt_i),
    .err_report_o   (err_report_o)
  );

endmodule

// File: rtl/lp_tlp_filter_chk.sv
module lp_tlp_filter_chk #(
  parameter int unsigned N_ERR = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pkt_valid_i,
  input logic [2:0]       pkt_kind_i,
  input logic             pkt_side_i,
  input logic             pkt_to_self_i,
  input logic             d3hot_i,
  input logic [N_ERR-1:0] err_valid_i,
  input logic [N_ERR-1:0] err_from_pkt_i,
  input logic             disp_valid_o,
  input logic [1:0]       disp_code_o,
  input logic [N_ERR-1:0] err_report_o
);

  // R1
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> disp_valid_o);

  // R1
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> !disp_valid_o);

  // R2
  d0_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !d3hot_i) |=> (disp_code_o == 2'd0));

  // R6
  sec_req_ur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && d3hot_i && pkt_side_i && pkt_kind_i != 3'd4) |=> (disp_code_o == 2'd2));

  // R7
  self_cpl_uc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && d3hot_i && pkt_kind_i == 3'd4 && pkt_to_self_i) |=> (disp_code_o == 2'd3));

  // R8
  thru_cpl_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_kind_i == 3'd4 && !pkt_to_self_i) |=> (disp_code_o == 2'd0));

  // R10
  d3_drop_other_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d3hot_i |=> ((err_report_o & ~$past(err_from_pkt_i)) == '0));

  // R11
  d0_err_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !d3hot_i |=> (err_report_o == $past(err_valid_i)));

  // R12
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!disp_valid_o && disp_code_o == 2'd0 && err_report_o == '0));

endmodule

bind lp_tlp_filter lp_tlp_filter_chk #(.N_ERR(N_ERR)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pkt_valid_i    (pkt_valid_i),
  .pkt_kind_i     (pkt_kind_i),
  .pkt_side_i     (pkt_side_i),
  .pkt_to_self_i  (pkt_to_self_i),
  .d3hot_i        (d3hot_i),
  .err_valid_i    (err_valid_i),
  .err_from_pkt_i (err_from_pkt_i),
  .disp_valid_o   (disp_valid_o),
  .disp_code_o    (disp_code_o),
  .err_report_o   (err_report_o)
);

// File: tb/lp_tlp_filter_tb_top.sv
module lp_tlp_filter_tb_top;

  localparam int N_ERR = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pkt_valid_i = 1'b0;
  logic [2:0]       pkt_kind_i = '0;
  logic             pkt_side_i = 1'b0;
  logic             pkt_to_self_i = 1'b0;
  logic             d3hot_i = 1'b0;
  logic [N_ERR-1:0] err_valid_i = '0;
  logic [N_ERR-1:0] err_from_pkt_i = '0;
  logic             disp_valid_o;
  logic [1:0]       disp_code_o;
  logic [N_ERR-1:0] err_report_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  lp_tlp_filter #(.N_ERR(N_ERR)) dut_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pkt_valid_i    (pkt_valid_i),
    .pkt_kind_i     (pkt_kind_i),
    .pkt_side_i     (pkt_side_i),
    .pkt_to_self_i  (pkt_to_self_i),
    .d3hot_i        (d3hot_i),
    .err_valid_i    (err_valid_i),
    .err_from_pkt_i (err_from_pkt_i),
    .disp_valid_o   (disp_valid_o),
    .disp_code_o    (disp_code_o),
    .err_report_o   (err_report_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, sample at the next falling edge (one register stage)
  task automatic send(input logic v, input logic [2:0] k, input logic s, input logic me,
                      input logic d3, input logic [N_ERR-1:0] ev, input logic [N_ERR-1:0] ep);
    @(negedge clk_i);
    pkt_valid_i = v; pkt_kind_i = k; pkt_side_i = s; pkt_to_self_i = me;
    d3hot_i = d3; err_valid_i = ev; err_from_pkt_i = ep;
    @(negedge clk_i);
    pkt_valid_i = 1'b0; err_valid_i = '0;
  endtask

  task automatic pkt_case(string req, input logic [2:0] k, input logic s, input logic me,
                          input logic d3, input logic [1:0] exp_code);
    send(1'b1, k, s, me, d3, '0, '0);
    check(req, disp_valid_o, 1);
    check(req, disp_code_o, exp_code);
  endtask

  task automatic t_reset;
    check("R12", disp_valid_o, 0);
    check("R12", disp_code_o, 0);
    check("R12", err_report_o, 0);
  endtask

  task automatic t_valid;
    send(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, '0, '0);
    check("R1", disp_valid_o, 0);
    send(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, '0, '0);
    check("R1", disp_valid_o, 1);
  endtask

  task automatic t_d0;
    for (int k = 0; k < 8; k++) begin
      pkt_case("R2", 3'(k), 1'b0, 1'b1, 1'b0, 2'd0);
      pkt_case("R2", 3'(k), 1'b1, 1'b0, 1'b0, 2'd0);
    end
  endtask

  task automatic t_d3_primary;
    pkt_case("R3", 3'd0, 1'b0, 1'b0, 1'b1, 2'd1);
    pkt_case("R3", 3'd0, 1'b0, 1'b1, 1'b1, 2'd1);
    pkt_case("R4", 3'd3, 1'b0, 1'b1, 1'b1, 2'd1);
    pkt_case("R5", 3'd3, 1'b0, 1'b0, 1'b1, 2'd2);
    pkt_case("R5", 3'd1, 1'b0, 1'b1, 1'b1, 2'd2);
    pkt_case("R5", 3'd2, 1'b0, 1'b0, 1'b1, 2'd2);
    for (int k = 5; k < 8; k++) pkt_case("R5", 3'(k), 1'b0, 1'b1, 1'b1, 2'd2);
  endtask

  task automatic t_d3_secondary;
    for (int k = 0; k < 8; k++) begin
      if (k == 4) continue;
      pkt_case("R6", 3'(k), 1'b1, 1'b1, 1'b1, 2'd2);
      pkt_case("R6", 3'(k), 1'b1, 1'b0, 1'b1, 2'd2);
    end
  endtask

  task automatic t_cpl;
    pkt_case("R7", 3'd4, 1'b0, 1'b1, 1'b1, 2'd3);
    pkt_case("R7", 3'd4, 1'b1, 1'b1, 1'b1, 2'd3);
    pkt_case("R8", 3'd4, 1'b0, 1'b0, 1'b1, 2'd0);
    pkt_case("R8", 3'd4, 1'b1, 1'b0, 1'b1, 2'd0);
    pkt_case("R8", 3'd4, 1'b1, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_err;
    send(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 4'b1111, 4'b0101);
    check("R9", err_report_o & 4'b0101, 4'b0101);
    check("R10", err_report_o & 4'b1010, 4'b0000);
    send(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 4'b0010, 4'b1101);
    check("R10", err_report_o, 4'b0000);
    send(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'b1011, 4'b0001);
    check("R11", err_report_o, 4'b1011);
    send(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 4'b0000, 4'b1111);
    check("R9", err_report_o, 4'b0000);
  endtask

  // packet decision and error gating in one cycle, with a power-state change
  task automatic t_same_cycle;
    send(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 4'b0011, 4'b0001);
    check("R2", disp_code_o, 0);
    check("R11", err_report_o, 4'b0011);
    send(1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 4'b1110, 4'b1000);
    check("R5", disp_code_o, 2);
    check("R10", err_report_o, 4'b1000);
    send(1'b1, 3'd4, 1'b1, 1'b1, 1'b0, 4'b0110, 4'b0000);
    check("R2", disp_code_o, 0);
    check("R11", err_report_o, 4'b0110);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_valid();
    t_d0();
    t_d3_primary();
    t_d3_secondary();
    t_cpl();
    t_err();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule